// File: doc/BRIEF.md
# Stack Push/Pop Transfer Sequencer

This block carries out the multi-word stack transfer of a compact instruction set: it stores a chosen subset of the eight low registers onto a full-descending stack, or loads them back. An optional extra slot is added to the transfer. On a store it holds the link register, and on a load it holds the program counter. The block performs one register-file access and one single-word memory access per cycle. It marks each memory access as either the opening access of a burst or a follow-on access. When it finishes it reports the new stack pointer.

A transfer begins on a one-cycle start strobe. The strobe comes with a direction select, an extra-slot flag, an 8-bit register list and the current stack pointer. The register-file read port and the memory read data are both combinational. A memory store or a register write takes effect on the clock edge that ends its access cycle. The transfer ends with a single-cycle completion pulse. On a load, that pulse falls in an internal idle cycle with no bus access. If the program counter was reloaded, the pulse comes together with a pipeline-flush indication.

Top module: `stk_xfer_seq`

## Requirements
- R1: On a push, the link register (index 14) is stored first when the extra flag is set. The listed registers follow in descending index order, 7 down to 0, where list bit k selects register k.
- R2: On a push, the stack pointer drops by 4 before each word is stored. The k-th store (k from 0) goes to sp-4(k+1), and the final sp_o is sp-4n.
- R3: On a pop, the listed registers are loaded in ascending index order, 0 up to 7. The program counter (index 15) is loaded last, and only when the extra flag is set. The k-th load reads sp+4k, and the final sp_o is sp+4n.
- R4: A value loaded into the program counter is written with bit 0 cleared. flush_o is high exactly in the completion cycle of a pop that loaded the program counter, and low otherwise.
- R5: The first memory access of a transfer has mem_seq_o low (non-sequential). Every later access of the same transfer has mem_seq_o high.
- R6: The n accesses fill the n cycles after the start is taken. done_o is then high for exactly one cycle, the (n+1)-th, and that cycle has no memory access. For a pop, this cycle is the idle cycle after the last load.
- R7: A start strobe that arrives while a transfer is in progress is ignored. The transfer keeps its accesses, its count and its final stack pointer, and no second transfer follows.
- R8: A transfer with an empty list and the extra flag clear makes no access. It raises done_o in the first cycle after the start and leaves the stack pointer unchanged.
- R9: While reset is asserted, done_o, flush_o, mem_req_o and rf_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| pop_i | input | 1 | 1 = load from stack, 0 = store to stack |
| extra_i | input | 1 | Adds the link register (push) or the program counter (pop) |
| rlist_i | input | 8 | Low-register list, bit k selects register k |
| sp_i | input | 32 | Stack pointer at start |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data (combinational) |
| mem_seq_o | output | 1 | 1 = sequential, 0 = non-sequential |
| sp_o | output | 32 | Updated stack pointer, valid at done_o |
| done_o | output | 1 | Completion pulse |
| flush_o | output | 1 | Pipeline flush, with done_o |

## Verification
The bench checks the two walking orders against each other. A design that scans the list the same way in both directions would store or load registers at mirrored addresses, and the per-access address and index checks would catch it. It loads an odd value into the program counter: if bit 0 is not cleared, or if flush_o is not tied to that one case, the written value or the flag in the done cycle is wrong. It also covers a transfer made of only the extra slot, an empty transfer, and a second start issued in mid-transfer. A design that restarted on that strobe, or dropped its first-access marking, would show an extra access, a shifted done cycle or a wrong mem_seq_o on the first access.

// File: rtl/stk_xfer_pkg.sv
package stk_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WRAP = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_pick.sv
// Picks the next slot from a pending mask: highest index or lowest index first.
module stk_pick #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] mask_i,
  input  logic         hi_first_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |mask_i;
    if (hi_first_i) begin
      for (int i = 0; i < N; i++)
        if (mask_i[i]) idx_o = W'(i);
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (mask_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/stk_sp_step.sv
module stk_sp_step #(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic [DW-1:0] sp_i,
  input  logic          up_i,
  output logic [DW-1:0] nxt_o
);
  always_comb nxt_o = up_i ? sp_i + DW'(STEP) : sp_i - DW'(STEP);
endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq
  import stk_xfer_pkg::*;
#(
  parameter int DW     = 32,
  parameter int LIST_W = 8,
  parameter int NSLOT  = 16,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  parameter int WBYTES = 4,
  localparam int AW    = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pop_i,
  input  logic              extra_i,
  input  logic [LIST_W-1:0] rlist_i,
  input  logic [DW-1:0]     sp_i,
  output logic [AW-1:0]     rf_raddr_o,
  input  logic [DW-1:0]     rf_rdata_i,
  output logic              rf_we_o,
  output logic [AW-1:0]     rf_waddr_o,
  output logic [DW-1:0]     rf_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              mem_seq_o,
  output logic [DW-1:0]     sp_o,
  output logic              done_o,
  output logic              flush_o
);
  stk_state_e       state_q;
  logic [NSLOT-1:0] pend_q, init_mask, pend_nxt;
  logic [DW-1:0]    sp_q, sp_nxt;
  logic             pop_q, first_q, flush_q;
  logic [AW-1:0]    cur_idx;
  logic             cur_any, in_xfer, cur_is_pc;

  // Push takes the highest pending slot (LR, then 7..0); pop the lowest (0..7, then PC).
  stk_pick #(.N(NSLOT)) u_pick (
    .mask_i    (pend_q),
    .hi_first_i(~pop_q),
    .idx_o     (cur_idx),
    .any_o     (cur_any)
  );

  stk_sp_step #(.DW(DW), .STEP(WBYTES)) u_step (
    .sp_i (sp_q),
    .up_i (pop_q),
    .nxt_o(sp_nxt)
  );

  always_comb begin
    init_mask = '0;
    init_mask[LIST_W-1:0] = rlist_i;
    if (extra_i) init_mask[pop_i ? PC_IDX : LR_IDX] = 1'b1;
  end

  always_comb pend_nxt = pend_q & ~(NSLOT'(1) << cur_idx);

  assign in_xfer   = (state_q == ST_XFER) && cur_any;
  assign cur_is_pc = (cur_idx == AW'(PC_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      sp_q    <= '0;
      pop_q   <= 1'b0;
      first_q <= 1'b1;
      flush_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pend_q  <= init_mask;
          sp_q    <= sp_i;
          pop_q   <= pop_i;
          first_q <= 1'b1;
          flush_q <= 1'b0;
          state_q <= (init_mask == '0) ? ST_WRAP : ST_XFER;
        end
        ST_XFER: begin
          pend_q  <= pend_nxt;
          sp_q    <= sp_nxt;
          first_q <= 1'b0;
          if (pop_q && cur_is_pc) flush_q <= 1'b1;
          if (pend_nxt == '0) state_q <= ST_WRAP;
        end
        ST_WRAP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = in_xfer;
    mem_we_o    = in_xfer && !pop_q;
    mem_addr_o  = pop_q ? sp_q : sp_nxt;
    mem_wdata_o = rf_rdata_i;
    mem_seq_o   = in_xfer && !first_q;
    rf_raddr_o  = cur_idx;
    rf_we_o     = in_xfer && pop_q;
    rf_waddr_o  = cur_idx;
    rf_wdata_o  = cur_is_pc ? {mem_rdata_i[DW-1:1], 1'b0} : mem_rdata_i;
    done_o      = (state_q == ST_WRAP);
    flush_o     = done_o && flush_q;
    sp_o        = sp_q;
  end
endmodule

// File: rtl/stk_xfer_chk.sv
module stk_xfer_chk #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int PC_IDX = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_seq_o,
  input logic          rf_we_o,
  input logic [AW-1:0] rf_waddr_o,
  input logic [DW-1:0] rf_wdata_o,
  input logic          done_o,
  input logic          flush_o
);
  assert_push_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && $past(mem_req_o) |-> mem_addr_o == $past(mem_addr_o) - DW'(4));

  assert_pop_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && $past(mem_req_o) |-> mem_addr_o == $past(mem_addr_o) + DW'(4));

  assert_pc_even_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && rf_waddr_o == AW'(PC_IDX) |-> !rf_wdata_o[0]);

  assert_flush_with_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> done_o);

  assert_first_nseq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !$past(mem_req_o) |-> !mem_seq_o);

  assert_later_seq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> mem_seq_o);

  assert_done_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  always_comb
    if (!rst_ni) assert_reset_quiet_R9: assert (!done_o && !flush_o && !mem_req_o && !rf_we_o);
endmodule

bind stk_xfer_seq stk_xfer_chk #(.DW(DW), .AW(AW), .PC_IDX(PC_IDX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .mem_seq_o (mem_seq_o),
  .rf_we_o   (rf_we_o),
  .rf_waddr_o(rf_waddr_o),
  .rf_wdata_o(rf_wdata_o),
  .done_o    (done_o),
  .flush_o   (flush_o)
);

// File: tb/stk_xfer_seq_tb.sv
module stk_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, pop = 1'b0, extra = 1'b0;
  logic [7:0]  rlist = '0;
  logic [31:0] sp = '0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, sp_out;
  logic        rf_we, mem_req, mem_we, mem_seq, done, flush;

  logic [31:0] rf  [16];
  logic [31:0] mem [64];

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  stk_xfer_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pop_i(pop), .extra_i(extra),
    .rlist_i(rlist), .sp_i(sp), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_seq_o(mem_seq),
    .sp_o(sp_out), .done_o(done), .flush_o(flush)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rf_init(int i);
    return 32'h1000_0000 + 32'(i) * 32'h111;
  endfunction

  function automatic logic [31:0] mem_init(int i);
    return 32'hA500_0000 + 32'(i) * 32'h10 + 32'h3;  // odd on purpose
  endfunction

  // One transfer; poke = issue a second start in cycle 2.
  task automatic run(input bit p, input bit x, input logic [7:0] rl,
                     input logic [31:0] s, input bit poke, input string req);
    int order[10];
    int n = 0;
    int acc = 0;
    bit seen_done = 0;
    for (int i = 0; i < 16; i++) rf[i] = rf_init(i);
    for (int i = 0; i < 64; i++) mem[i] = mem_init(i);
    if (!p) begin
      if (x) begin order[n] = 14; n++; end
      for (int r = 7; r >= 0; r--) if (rl[r]) begin order[n] = r; n++; end
    end else begin
      for (int r = 0; r < 8; r++) if (rl[r]) begin order[n] = r; n++; end
      if (x) begin order[n] = 15; n++; end
    end
    @(negedge clk);
    start = 1'b1; pop = p; extra = x; rlist = rl; sp = s;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc <= 14; cyc++) begin
      if (poke && cyc == 2) begin
        start = 1'b1; pop = ~p; extra = 1'b1; rlist = 8'hFF; sp = 32'h40;
      end else start = 1'b0;
      if (mem_req) begin
        if (acc < n) begin
          logic [31:0] ea;
          ea = p ? s + 32'(4 * acc) : s - 32'(4 * (acc + 1));
          chk(mem_addr == ea, p ? "R3" : "R2", "address", mem_addr, ea);
          chk(mem_seq == (acc != 0), "R5", "seq tag", 32'(mem_seq), 32'(acc != 0));
          if (!p) begin
            chk(mem_we && rf_raddr == 4'(order[acc]), "R1", "store index",
                32'(rf_raddr), 32'(order[acc]));
            chk(mem_wdata == rf_init(order[acc]), "R1", "store data", mem_wdata,
                rf_init(order[acc]));
          end else begin
            logic [31:0] ed;
            ed = mem_init(int'(ea[7:2]));
            if (order[acc] == 15) ed[0] = 1'b0;
            chk(rf_we && rf_waddr == 4'(order[acc]), "R3", "load index",
                32'(rf_waddr), 32'(order[acc]));
            chk(rf_wdata == ed, order[acc] == 15 ? "R4" : "R3", "load data", rf_wdata, ed);
          end
        end
        acc++;
      end
      if (done) begin
        logic [31:0] es;
        es = p ? s + 32'(4 * n) : s - 32'(4 * n);
        seen_done = 1;
        chk(cyc == n + 1, "R6", {req, " done cycle"}, 32'(cyc), 32'(n + 1));
        chk(!mem_req, "R6", "done cycle quiet", 32'(mem_req), 32'd0);
        chk(acc == n, req, "access count", 32'(acc), 32'(n));
        chk(sp_out == es, p ? "R3" : "R2", "final sp", sp_out, es);
        chk(flush == (p && x), "R4", "flush", 32'(flush), 32'(p && x));
        @(negedge clk);
        start = 1'b0;
        break;
      end
      @(negedge clk);
    end
    chk(seen_done, "R6", {req, " done seen"}, 32'(seen_done), 32'd1);
    for (int k = 0; k < 4; k++) begin
      chk(!mem_req && !done, "R7", "quiet after done", {30'd0, mem_req, done}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(!done && !flush && !mem_req && !rf_we, "R9", "reset outputs",
        {28'd0, done, flush, mem_req, rf_we}, 32'd0);
  endtask

  task automatic t_push_lr;     run(0, 1, 8'hA5, 32'h80, 0, "R1"); endtask
  task automatic t_push_single; run(0, 0, 8'h10, 32'h80, 0, "R2"); endtask
  task automatic t_pop_plain;   run(1, 0, 8'h3C, 32'h80, 0, "R3"); endtask
  task automatic t_pop_pc;      run(1, 1, 8'h81, 32'h80, 0, "R4"); endtask
  task automatic t_pop_only_pc; run(1, 1, 8'h00, 32'h84, 0, "R4"); endtask
  task automatic t_empty;       run(0, 0, 8'h00, 32'h80, 0, "R8"); endtask
  task automatic t_push_poke;   run(0, 1, 8'hFF, 32'h80, 1, "R7"); endtask
  task automatic t_pop_poke;    run(1, 1, 8'h5A, 32'h60, 1, "R7"); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_push_lr();
    t_push_single();
    t_pop_plain();
    t_pop_pc();
    t_pop_only_pc();
    t_empty();
    t_push_poke();
    t_pop_poke();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule